// File: doc/BRIEF.md
# Segmented I/O Address Translator

This block turns the addresses that devices present for DMA into real memory addresses. The I/O address space is cut into 256 MB segments. The segment number indexes a segment table whose base is held in an origin register. The selected segment entry gives the location, length and page size of that segment's page table. A second lookup then fetches the page entry. That entry supplies the real page number, the read and write permissions, the requester ID that may use the page, and a few attributes that the block carries through without acting on them.

Table memory sits outside the block and is reached through one synchronous read port, with data returned the cycle after the read strobe. The block accepts one request at a time and drops `reqReady` while a walk is under way. Every request gets exactly one response pulse. That response carries either a permitted translation, a segment fault or a page fault. When translation is switched off, the address passes through unchanged.

Top module: `seg_io_xlate`

## Requirements
- R1: When `stOrigin` bit 63 or `cmdCfg` bit 47 is clear at acceptance, the response is registered on the accepting edge with `rspAddr` equal to the zero-extended request address, `rspPermit`=1, both fault flags 0, and no table read issued.
- R2: The segment entry is read from `{stOrigin[RA_W-1:12], 12'h000}` plus 8 times the segment index (`reqAddr >> 28`). The page entry is read from the segment entry's table base (bits RA_W-1:12, low 12 bits zero) plus 8 times the page index. Every read address is 8-byte aligned.
- R3: A segment entry with bit 63 clear gives a segment fault, registered two edges after acceptance, after exactly one table read. On any fault `rspAddr` carries the I/O address.
- R4: The segment entry's page-size field (bits 2:0) picks the page shift: 1→12 (4 KB), 3→16 (64 KB), 5→20 (1 MB), 7→24 (16 MB). Any even value gives a segment fault.
- R5: The page index is the I/O address bits 27:shift. When the index divided by 512 exceeds the segment entry's length field (bits 11:5, table size in 4 KB pages minus one), the result is a page fault. An index on the last entry of the table is still looked up normally.
- R6: A write needs page-entry bit 63 and a read needs bit 62, otherwise the result is a page fault. An all-zero page entry faults for both directions.
- R7: Page-entry bits 10:0 must equal `reqId`, otherwise the result is a page fault.
- R8: A permitted translation is registered four edges after acceptance, after two table reads. `rspAddr` is then the page entry's bits RA_W-1:shift joined with the I/O address bits shift-1:0.
- R9: On a permitted translation, `rspAttr` = {page bit 61, page bits 60:59, page bit 11}. On any other response `rspAttr` is 0. The segment entry's bit 62 has no effect on the result.
- R10: After reset `reqReady`=1 and `rspValid`=0. While a walk is in progress `reqReady` is 0. Each accepted request yields one `rspValid` pulse with exactly one of `rspPermit`, `rspSegFault`, `rspPageFault` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stOrigin | input | 64 | Bit 63 origin enable; bits RA_W-1:12 segment table base |
| cmdCfg | input | 64 | Bit 47 translation enable; other bits unused |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqAddr | input | IOA_W | I/O address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqId | input | 11 | Requester ID |
| memRdEn | output | 1 | Table read strobe |
| memRdAddr | output | RA_W | Table read byte address |
| memRdData | input | 64 | Table read data, one cycle after strobe |
| rspValid | output | 1 | Response pulse |
| rspAddr | output | RA_W | Real address, or I/O address on fault |
| rspPermit | output | 1 | Access permitted |
| rspSegFault | output | 1 | Segment fault |
| rspPageFault | output | 1 | Page fault |
| rspAttr | output | 4 | {coherence, ordering[1:0], cache hint} |

## Verification
The results arrive at three fixed distances from the accepting edge. A bypassed request is answered on that edge. A segment fault follows two edges later, and a full walk follows four edges later, after one and two table reads. The driver counts clock edges and table reads from the edge of acceptance and pushes the expected latency and read count with each item. The monitor samples at the falling edge after the response pulse and compares those counts together with the address, flags and attributes. For multi-cycle walks the driver also confirms that `reqReady` is low in the cycle after acceptance.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

  localparam int SEG_SHIFT   = 28;
  localparam int IDX_W       = SEG_SHIFT - 12;
  localparam int RID_W       = 11;
  localparam int CFG_EN_BIT  = 47;
  localparam int ORG_EN_BIT  = 63;

  typedef struct packed {
    logic accept;
    logic rdSte;
    logic rdPte;
    logic capSte;
    logic doneOff;
    logic doneSeg;
    logic donePte;
  } sxlStrobe_t;

  function automatic logic [4:0] pageShift(input logic [2:0] ps);
    case (ps)
      3'd3:    return 5'd16;
      3'd5:    return 5'd20;
      3'd7:    return 5'd24;
      default: return 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/sxl_ctrl.sv
module sxl_ctrl
  import sxl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       transOn,
  input  logic       segOk,
  output logic       reqReady,
  output sxlStrobe_t strb
);

  typedef enum logic [2:0] {ST_IDLE, ST_SEG_RD, ST_SEG_WT, ST_PG_RD, ST_PG_WT} walkState_t;
  walkState_t state, nxtState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    strb     = '0;
    nxtState = state;
    reqReady = (state == ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.accept = 1'b1;
          if (transOn) nxtState = ST_SEG_RD;
          else         strb.doneOff = 1'b1;
        end
      end
      ST_SEG_RD: begin
        strb.rdSte = 1'b1;
        nxtState   = ST_SEG_WT;
      end
      ST_SEG_WT: begin
        if (segOk) begin
          strb.capSte = 1'b1;
          nxtState    = ST_PG_RD;
        end else begin
          strb.doneSeg = 1'b1;
          nxtState     = ST_IDLE;
        end
      end
      ST_PG_RD: begin
        strb.rdPte = 1'b1;
        nxtState   = ST_PG_WT;
      end
      ST_PG_WT: begin
        strb.donePte = 1'b1;
        nxtState     = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  // R3: a rejected segment entry never leads to a page read
  a_r3_no_page_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneSeg |=> !strb.rdPte);

endmodule

// File: rtl/sxl_dpath.sv
module sxl_dpath
  import sxl_pkg::*;
#(
  parameter int IOA_W = 36,
  parameter int RA_W  = 42
) (
  input  logic             clk,
  input  logic             rstN,
  input  sxlStrobe_t       strb,
  input  logic [63:0]      stOrigin,
  input  logic [63:0]      cmdCfg,
  input  logic [IOA_W-1:0] reqAddr,
  input  logic             reqWrite,
  input  logic [RID_W-1:0] reqId,
  input  logic [63:0]      memRdData,
  output logic             transOn,
  output logic             segOk,
  output logic             memRdEn,
  output logic [RA_W-1:0]  memRdAddr,
  output logic             rspValid,
  output logic [RA_W-1:0]  rspAddr,
  output logic             rspPermit,
  output logic             rspSegFault,
  output logic             rspPageFault,
  output logic [3:0]       rspAttr
);

  localparam int SEG_W  = IOA_W - SEG_SHIFT;
  localparam int BASE_W = RA_W - 12;

  logic [IOA_W-1:0]  addrQ;
  logic              writeQ;
  logic [RID_W-1:0]  idQ;
  logic [BASE_W-1:0] steBaseQ;
  logic [6:0]        steLenQ;
  logic [2:0]        stePsQ;

  wire unusedBits = ^{stOrigin[62:RA_W], stOrigin[11:0], cmdCfg[63:CFG_EN_BIT+1],
                      cmdCfg[CFG_EN_BIT-1:0], memRdData[58:RA_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      writeQ   <= 1'b0;
      idQ      <= '0;
      steBaseQ <= '0;
      steLenQ  <= '0;
      stePsQ   <= '0;
    end else begin
      if (strb.accept) begin
        addrQ  <= reqAddr;
        writeQ <= reqWrite;
        idQ    <= reqId;
      end
      if (strb.capSte) begin
        steBaseQ <= memRdData[RA_W-1:12];
        steLenQ  <= memRdData[11:5];
        stePsQ   <= memRdData[2:0];
      end
    end
  end

  assign transOn = stOrigin[ORG_EN_BIT] & cmdCfg[CFG_EN_BIT];
  // valid bit set and an odd page-size code
  assign segOk   = memRdData[63] & memRdData[0];

  logic [SEG_W-1:0]  segIdx;
  logic [4:0]        shiftQ;
  logic [IDX_W-1:0]  pageIdx;
  logic [RA_W-1:0]   steAddr, pteAddr, offMask, ioaWide, xlAddr;
  logic              overLen, permOk, idOk, pageOk;

  assign segIdx  = addrQ[IOA_W-1:SEG_SHIFT];
  assign steAddr = {stOrigin[RA_W-1:12], 12'h000} + RA_W'({segIdx, 3'b000});
  assign shiftQ  = pageShift(stePsQ);
  assign pageIdx = IDX_W'(addrQ[SEG_SHIFT-1:0] >> shiftQ);
  assign pteAddr = {steBaseQ, 12'h000} + RA_W'({pageIdx, 3'b000});

  assign memRdEn   = strb.rdSte | strb.rdPte;
  assign memRdAddr = strb.rdPte ? pteAddr : steAddr;

  assign overLen = pageIdx[IDX_W-1:9] > steLenQ;
  assign permOk  = writeQ ? memRdData[63] : memRdData[62];
  assign idOk    = memRdData[RID_W-1:0] == idQ;
  assign pageOk  = !overLen && permOk && idOk;

  assign offMask = ~({RA_W{1'b1}} << shiftQ);
  assign ioaWide = RA_W'(addrQ);
  assign xlAddr  = (memRdData[RA_W-1:0] & ~offMask) | (ioaWide & offMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspAddr      <= '0;
      rspPermit    <= 1'b0;
      rspSegFault  <= 1'b0;
      rspPageFault <= 1'b0;
      rspAttr      <= '0;
    end else begin
      rspValid <= strb.doneOff | strb.doneSeg | strb.donePte;
      if (strb.doneOff) begin
        rspAddr      <= RA_W'(reqAddr);
        rspPermit    <= 1'b1;
        rspSegFault  <= 1'b0;
        rspPageFault <= 1'b0;
        rspAttr      <= '0;
      end else if (strb.doneSeg) begin
        rspAddr      <= ioaWide;
        rspPermit    <= 1'b0;
        rspSegFault  <= 1'b1;
        rspPageFault <= 1'b0;
        rspAttr      <= '0;
      end else if (strb.donePte) begin
        rspSegFault <= 1'b0;
        if (pageOk) begin
          rspAddr      <= xlAddr;
          rspPermit    <= 1'b1;
          rspPageFault <= 1'b0;
          rspAttr      <= {memRdData[61], memRdData[60:59], memRdData[11]};
        end else begin
          rspAddr      <= ioaWide;
          rspPermit    <= 1'b0;
          rspPageFault <= 1'b1;
          rspAttr      <= '0;
        end
      end
    end
  end

  // R10: one outcome per response
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspPermit, rspSegFault, rspPageFault}) == 1);

  // R8: the low 4 KB offset always survives translation
  a_r8_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> rspAddr[11:0] == addrQ[11:0]);

  // R2: table reads land on entry boundaries
  a_r2_aligned_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> memRdAddr[2:0] == 3'b000);

  // R9: attributes only accompany a permitted translation
  a_r9_attr_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspPermit) |-> rspAttr == 4'h0);

endmodule

// File: rtl/seg_io_xlate.sv
module seg_io_xlate
  import sxl_pkg::*;
#(
  parameter int IOA_W = 36,
  parameter int RA_W  = 42
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [63:0]      stOrigin,
  input  logic [63:0]      cmdCfg,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [IOA_W-1:0] reqAddr,
  input  logic             reqWrite,
  input  logic [10:0]      reqId,
  output logic             memRdEn,
  output logic [RA_W-1:0]  memRdAddr,
  input  logic [63:0]      memRdData,
  output logic             rspValid,
  output logic [RA_W-1:0]  rspAddr,
  output logic             rspPermit,
  output logic             rspSegFault,
  output logic             rspPageFault,
  output logic [3:0]       rspAttr
);

  sxlStrobe_t strb;
  logic       transOn, segOk;

  sxl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .transOn  (transOn),
    .segOk    (segOk),
    .reqReady (reqReady),
    .strb     (strb)
  );

  sxl_dpath #(.IOA_W(IOA_W), .RA_W(RA_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .stOrigin     (stOrigin),
    .cmdCfg       (cmdCfg),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqId        (reqId),
    .memRdData    (memRdData),
    .transOn      (transOn),
    .segOk        (segOk),
    .memRdEn      (memRdEn),
    .memRdAddr    (memRdAddr),
    .rspValid     (rspValid),
    .rspAddr      (rspAddr),
    .rspPermit    (rspPermit),
    .rspSegFault  (rspSegFault),
    .rspPageFault (rspPageFault),
    .rspAttr      (rspAttr)
  );

  // R1: bypass answers on the accepting edge with the address unchanged
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(stOrigin[63] && cmdCfg[47]))
      |=> rspValid && rspPermit && rspAddr == RA_W'($past(reqAddr)));

endmodule

// File: tb/seg_io_xlate_tb.sv
module seg_io_xlate_tb;

  localparam int IOA_W = 36;
  localparam int RA_W  = 42;
  localparam logic [RA_W-1:0] ORG = 42'h100000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [63:0]      stOrigin = '0;
  logic [63:0]      cmdCfg = '0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [IOA_W-1:0] reqAddr = '0;
  logic             reqWrite = 1'b0;
  logic [10:0]      reqId = '0;
  logic             memRdEn;
  logic [RA_W-1:0]  memRdAddr;
  logic [63:0]      memRdData = '0;
  logic             rspValid;
  logic [RA_W-1:0]  rspAddr;
  logic             rspPermit, rspSegFault, rspPageFault;
  logic [3:0]       rspAttr;

  seg_io_xlate #(.IOA_W(IOA_W), .RA_W(RA_W)) u_dut (
    .clk(clk), .rstN(rstN), .stOrigin(stOrigin), .cmdCfg(cmdCfg),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqId(reqId), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspPermit(rspPermit), .rspSegFault(rspSegFault),
    .rspPageFault(rspPageFault), .rspAttr(rspAttr)
  );

  always #4 clk = ~clk;

  logic [63:0] mem [logic [RA_W-1:0]];

  function automatic logic [63:0] rdMem(input logic [RA_W-1:0] ad);
    return mem.exists(ad) ? mem[ad] : 64'd0;
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= rdMem(memRdAddr);

  int cycleCnt = 0;
  int rdCnt = 0;
  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (memRdEn) rdCnt <= rdCnt + 1;
  end

  typedef struct {
    logic [RA_W-1:0] addr;
    logic [2:0]      flags;
    logic [3:0]      attr;
    int              lat;
    int              reads;
    int              cyc0;
    int              rd0;
    string           tag;
  } exp_t;

  exp_t expQ[$];
  int nChecks = 0;
  int nErrors = 0;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkSte(input logic v, input logic h, input logic [63:0] base,
                                        input logic [6:0] len, input logic [2:0] ps);
    return {v, h, 62'd0} | (base & 64'h3FFF_FFFF_FFFF_F000) | (64'(len) << 5) | 64'(ps);
  endfunction

  function automatic logic [63:0] mkPte(input logic w, input logic r, input logic m,
                                        input logic [1:0] ord, input logic [63:0] rpn,
                                        input logic h, input logic [10:0] id);
    return {w, r, m, ord, 59'd0} | (rpn & 64'h07FF_FFFF_FFFF_F000) | (64'(h) << 11) | 64'(id);
  endfunction

  // expectation built from the requirements; flags = {permit, seg, page}
  function automatic exp_t model(input logic [IOA_W-1:0] a, input logic wr,
                                 input logic [10:0] id, input string tag);
    exp_t e;
    logic [63:0] ste, pte;
    logic [RA_W-1:0] sa, pa, mask;
    logic [15:0] idx;
    int sh;
    e.tag = tag; e.attr = 4'h0; e.addr = RA_W'(a); e.cyc0 = 0; e.rd0 = 0;
    if (!(stOrigin[63] && cmdCfg[47])) begin
      e.flags = 3'b100; e.lat = 0; e.reads = 0;
      return e;
    end
    sa  = {stOrigin[RA_W-1:12], 12'h000} + (RA_W'(a[IOA_W-1:28]) << 3);
    ste = rdMem(sa);
    e.lat = 2; e.reads = 1;
    if (!ste[63] || !(ste[2:0] inside {3'd1, 3'd3, 3'd5, 3'd7})) begin
      e.flags = 3'b010;
      return e;
    end
    case (ste[2:0])
      3'd1: sh = 12;
      3'd3: sh = 16;
      3'd5: sh = 20;
      default: sh = 24;
    endcase
    idx = 16'(a[27:0] >> sh);
    pa  = {ste[RA_W-1:12], 12'h000} + (RA_W'(idx) << 3);
    pte = rdMem(pa);
    e.lat = 4; e.reads = 2;
    if ((idx[15:9] > ste[11:5]) || (wr ? !pte[63] : !pte[62]) || (pte[10:0] != id)) begin
      e.flags = 3'b001;
      return e;
    end
    mask    = (RA_W'(1) << sh) - RA_W'(1);
    e.addr  = (pte[RA_W-1:0] & ~mask) | (RA_W'(a) & mask);
    e.flags = 3'b100;
    e.attr  = {pte[61], pte[60:59], pte[11]};
    return e;
  endfunction

  task automatic send(input logic [IOA_W-1:0] a, input logic wr,
                      input logic [10:0] id, input string tag);
    exp_t e;
    e = model(a, wr, id, tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    e.cyc0 = cycleCnt + 1;
    e.rd0  = rdCnt;
    expQ.push_back(e);
    reqAddr = a; reqWrite = wr; reqId = id; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (e.lat > 0)
      check(reqReady == 1'b0, "R10", "ready during walk", 64'(reqReady), 64'd0);
    while (expQ.size() != 0) @(negedge clk);
  endtask

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10", "unexpected response", 64'(rspAddr), 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspAddr == e.addr, e.tag, "rspAddr", 64'(rspAddr), 64'(e.addr));
        check({rspPermit, rspSegFault, rspPageFault} == e.flags, e.tag,
              "flags {permit,seg,page}", 64'({rspPermit, rspSegFault, rspPageFault}), 64'(e.flags));
        check(rspAttr == e.attr, e.tag, "rspAttr", 64'(rspAttr), 64'(e.attr));
        check((cycleCnt - e.cyc0) == e.lat, e.tag, "latency", 64'(cycleCnt - e.cyc0), 64'(e.lat));
        check((rdCnt - e.rd0) == e.reads, e.tag, "table reads", 64'(rdCnt - e.rd0), 64'(e.reads));
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    // segment table
    mem[ORG + 42'd0]  = mkSte(1'b1, 1'b0, 64'h200000, 7'd1, 3'd1);
    mem[ORG + 42'd8]  = mkSte(1'b1, 1'b0, 64'h300000, 7'd0, 3'd7);
    mem[ORG + 42'd16] = mkSte(1'b0, 1'b0, 64'h600000, 7'd0, 3'd1);
    mem[ORG + 42'd24] = mkSte(1'b1, 1'b0, 64'h600000, 7'd0, 3'd2);
    mem[ORG + 42'd32] = mkSte(1'b1, 1'b1, 64'h400000, 7'd0, 3'd3);
    mem[ORG + 42'd40] = mkSte(1'b1, 1'b0, 64'h500000, 7'd0, 3'd5);
    // page tables
    mem[42'h200018] = mkPte(1'b1, 1'b1, 1'b1, 2'd2, 64'h1234_5000, 1'b1, 11'd5);
    mem[42'h200020] = mkPte(1'b0, 1'b1, 1'b0, 2'd0, 64'h2222_2000, 1'b0, 11'd5);
    mem[42'h201FF8] = mkPte(1'b0, 1'b1, 1'b0, 2'd1, 64'h0077_7000, 1'b0, 11'd5);
    mem[42'h300050] = mkPte(1'b1, 1'b1, 1'b0, 2'd1, 64'h2_3012_3000, 1'b0, 11'd9);
    mem[42'h400028] = mkPte(1'b1, 1'b0, 1'b0, 2'd3, 64'h5_5555_5000, 1'b0, 11'd7);
    mem[42'h500018] = mkPte(1'b1, 1'b1, 1'b1, 2'd0, 64'h3_4560_0000, 1'b1, 11'd2);

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "reset reqReady", 64'(reqReady), 64'd1);
    check(rspValid == 1'b0, "R10", "reset rspValid", 64'(rspValid), 64'd0);

    // R1: bypass with origin enable clear, then with command enable clear
    stOrigin = 64'(ORG);
    cmdCfg   = 64'd1 << 47;
    send(36'h1_2345_6789, 1'b0, 11'd0, "R1");
    stOrigin = (64'd1 << 63) | 64'(ORG);
    cmdCfg   = 64'd0;
    send(36'h3_0000_0040, 1'b1, 11'd3, "R1");
    cmdCfg   = 64'd1 << 47;

    // R8/R2: 4 KB page, read and write, expected 0x12345ABC, attr 4'b1101
    send(36'h0_0000_3ABC, 1'b0, 11'd5, "R8");
    send(36'h0_0000_3ABC, 1'b1, 11'd5, "R2");
    // R7: requester ID mismatch
    send(36'h0_0000_3ABC, 1'b0, 11'd6, "R7");
    // R6: read-only page, all-zero page
    send(36'h0_0000_4010, 1'b1, 11'd5, "R6");
    send(36'h0_0000_4010, 1'b0, 11'd5, "R6");
    send(36'h0_0000_5000, 1'b0, 11'd0, "R6");
    send(36'h0_0000_5000, 1'b1, 11'd0, "R6");
    // R5: last entry of a two-page table, then one past it
    send(36'h0_003F_F123, 1'b0, 11'd5, "R5");
    send(36'h0_0040_0123, 1'b0, 11'd5, "R5");
    // R4: 16 MB page with junk in the low page-number bits
    send(36'h1_0ABC_DEF0, 1'b1, 11'd9, "R4");
    // R3: invalid segment
    send(36'h2_0000_1000, 1'b0, 11'd0, "R3");
    // R4: illegal even page-size code
    send(36'h3_0000_0000, 1'b0, 11'd0, "R4");
    // R9: 64 KB page in a segment with cache hint set; write passes, read faults
    send(36'h4_0005_1234, 1'b1, 11'd7, "R9");
    send(36'h4_0005_1234, 1'b0, 11'd7, "R9");
    // R8: 1 MB page
    send(36'h5_0030_0042, 1'b0, 11'd2, "R8");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R10", "pending expectations", 64'(expQ.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule